// File: doc/BRIEF.md
# Single-Cycle Integer Execute Unit

This block carries out one 32-bit integer instruction per clock cycle for a small three-operand load/store style instruction set. It holds a bank of 32 general registers, each 32 bits wide. It decodes the presented word and reads both source registers. It picks the second operand from a register or from the extended 16-bit constant. It then produces the result in the same cycle and commits it to the destination register on the next rising clock edge.

The supported operations are register-register add, subtract, AND, OR, XOR and NOR, and register-constant add, AND, OR, XOR and load-upper. Anything else is flagged as illegal and commits nothing. The result, the write strobe and the write address are visible on the ports. A following instruction that reads a register therefore observes every earlier write.

Top module: `int_exec_unit`

## Requirements
- R1: After reset every register reads as zero.
- R2: Register-register forms (opcode 0) with function 32 (add) and 34 (subtract) give rs+rt and rs-rt modulo 2^32, with no overflow signalling.
- R3: Opcode 0 with function 36, 37, 38 and 39 gives rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt) respectively.
- R4: Opcode 8 adds rs to the 16-bit constant in bits [15:0] after sign extension.
- R5: Opcodes 12, 13 and 14 give rs AND, OR and XOR the constant zero-extended to 32 bits.
- R6: Opcode 15 yields the constant in bits [31:16] and zero in bits [15:0], whatever register the rs field names.
- R7: Register-register forms write to the register named by bits [15:11]. Constant forms write to the register named by bits [20:16]. wb_addr_o shows that field.
- R8: Register 0 always reads as zero. An instruction aimed at register 0 leaves wb_en_o low.
- R9: With valid high, an opcode other than 0, 8, 12 to 15, a function code outside the six listed, or a nonzero field [10:6] in a register-register form raises illegal_o for that cycle, holds wb_en_o low and changes no register.
- R10: With instr_valid_i low, wb_en_o and illegal_o stay low and no register changes.
- R11: A result is committed at the rising edge that ends its cycle, so the very next instruction reads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, clears the registers |
| instr_valid_i | input | 1 | The instruction word is to be executed this cycle |
| instr_i | input | 32 | Instruction word |
| result_o | output | 32 | Computed result for the current instruction |
| wb_en_o | output | 1 | The result is committed at the coming rising edge |
| wb_addr_o | output | 5 | Destination register index |
| illegal_o | output | 1 | Current valid instruction is not supported |

## Verification
result_o, wb_en_o, wb_addr_o and illegal_o are combinational in the presented word and the current register contents. They are due in the same cycle in which the word is driven. A register write becomes visible only to the instruction issued one cycle later. The bench drives each word just after a falling edge and compares the outputs 2 ns later, before the rising edge. It updates its own register model only after that edge, so each comparison sees exactly the state the design should hold. Ignored-input cases are checked through the result of a later read-back instruction.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

   localparam int INSTR_W = 32;
   localparam int OPC_W   = 6;
   localparam int FN_W    = 6;
   localparam int RIDX_W  = 5;
   localparam int SH_W    = 5;

   // field positions of the instruction word
   localparam int OPC_LSB = 26;
   localparam int RS_LSB  = 21;
   localparam int RT_LSB  = 16;
   localparam int RD_LSB  = 11;
   localparam int SH_LSB  = 6;

   localparam logic [OPC_W-1:0] OPC_REGREG = 6'd0;
   localparam logic [OPC_W-1:0] OPC_ADDC   = 6'd8;
   localparam logic [OPC_W-1:0] OPC_ANDC   = 6'd12;
   localparam logic [OPC_W-1:0] OPC_ORC    = 6'd13;
   localparam logic [OPC_W-1:0] OPC_XORC   = 6'd14;
   localparam logic [OPC_W-1:0] OPC_UPPER  = 6'd15;

   localparam logic [FN_W-1:0] FN_ADD = 6'd32;
   localparam logic [FN_W-1:0] FN_SUB = 6'd34;
   localparam logic [FN_W-1:0] FN_AND = 6'd36;
   localparam logic [FN_W-1:0] FN_OR  = 6'd37;
   localparam logic [FN_W-1:0] FN_XOR = 6'd38;
   localparam logic [FN_W-1:0] FN_NOR = 6'd39;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR,
      ALU_XOR,
      ALU_NOR,
      ALU_UPPER
   } alu_op_e;

   typedef enum logic [1:0] {
      SRCB_REG,
      SRCB_SEXT,
      SRCB_ZEXT
   } srcb_e;

   typedef struct packed {
      logic              legal;
      alu_op_e           op;
      srcb_e             srcb;
      logic [RIDX_W-1:0] dst;
   } dec_t;

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
   import int_exec_pkg::*;
(
   input  logic [OPC_W-1:0]  opc_i,
   input  logic [FN_W-1:0]   fn_i,
   input  logic [SH_W-1:0]   sh_i,
   input  logic [RIDX_W-1:0] rt_i,
   input  logic [RIDX_W-1:0] rd_i,
   output dec_t              dec_o
);

   always_comb begin
      dec_o       = '0;
      dec_o.legal = 1'b0;
      dec_o.op    = ALU_ADD;
      dec_o.srcb  = SRCB_REG;
      dec_o.dst   = rt_i;
      unique case (opc_i)
         OPC_REGREG: begin
            dec_o.dst  = rd_i;
            dec_o.srcb = SRCB_REG;
            dec_o.legal = (sh_i == '0);
            case (fn_i)
               FN_ADD:  dec_o.op = ALU_ADD;
               FN_SUB:  dec_o.op = ALU_SUB;
               FN_AND:  dec_o.op = ALU_AND;
               FN_OR:   dec_o.op = ALU_OR;
               FN_XOR:  dec_o.op = ALU_XOR;
               FN_NOR:  dec_o.op = ALU_NOR;
               default: dec_o.legal = 1'b0;
            endcase
         end
         OPC_ADDC: begin
            dec_o.legal = 1'b1;
            dec_o.op    = ALU_ADD;
            dec_o.srcb  = SRCB_SEXT;
         end
         OPC_ANDC: begin
            dec_o.legal = 1'b1;
            dec_o.op    = ALU_AND;
            dec_o.srcb  = SRCB_ZEXT;
         end
         OPC_ORC: begin
            dec_o.legal = 1'b1;
            dec_o.op    = ALU_OR;
            dec_o.srcb  = SRCB_ZEXT;
         end
         OPC_XORC: begin
            dec_o.legal = 1'b1;
            dec_o.op    = ALU_XOR;
            dec_o.srcb  = SRCB_ZEXT;
         end
         OPC_UPPER: begin
            dec_o.legal = 1'b1;
            dec_o.op    = ALU_UPPER;
            dec_o.srcb  = SRCB_ZEXT;
         end
         default: dec_o.legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/int_exec_regfile.sv
module int_exec_regfile #(
   parameter int DATA_W     = 32,
   parameter int REGS       = 32,
   parameter bit RESET_BANK = 1'b1,
   localparam int AW        = $clog2(REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     ra_a_i,
   input  logic [AW-1:0]     ra_b_i,
   output logic [DATA_W-1:0] rd_a_o,
   output logic [DATA_W-1:0] rd_b_o,
   input  logic              we_i,
   input  logic [AW-1:0]     wa_i,
   input  logic [DATA_W-1:0] wd_i
);

   logic [DATA_W-1:0] bank [REGS];

   for (genvar i = 0; i < REGS; i++) begin : g_ent
      if (i == 0) begin : g_zero
         assign bank[i] = '0;
      end else begin : g_live
         logic [DATA_W-1:0] q;
         logic              hit;
         assign hit = we_i && (wa_i == AW'(i));
         if (RESET_BANK) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   q <= '0;
               else if (hit) q <= wd_i;
            end
         end else begin : g_nrst
            always_ff @(posedge clk) begin
               if (hit) q <= wd_i;
            end
         end
         assign bank[i] = q;
      end
   end

   assign rd_a_o = bank[ra_a_i];
   assign rd_b_o = bank[ra_b_i];

endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
   import int_exec_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int IMM_W        = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  alu_op_e           op_i,
   output logic [DATA_W-1:0] y_o
);

   logic [DATA_W-1:0] arith;
   logic              is_sub;

   assign is_sub = (op_i == ALU_SUB);

   if (SHARED_ADDER) begin : g_shared
      logic [DATA_W-1:0] b_inv;
      assign b_inv = b_i ^ {DATA_W{is_sub}};
      assign arith = a_i + b_inv + {{(DATA_W-1){1'b0}}, is_sub};
   end else begin : g_split
      logic [DATA_W-1:0] sum;
      logic [DATA_W-1:0] dif;
      assign sum   = a_i + b_i;
      assign dif   = a_i - b_i;
      assign arith = is_sub ? dif : sum;
   end

   always_comb begin
      unique case (op_i)
         ALU_ADD,
         ALU_SUB:   y_o = arith;
         ALU_AND:   y_o = a_i & b_i;
         ALU_OR:    y_o = a_i | b_i;
         ALU_XOR:   y_o = a_i ^ b_i;
         ALU_NOR:   y_o = ~(a_i | b_i);
         ALU_UPPER: y_o = b_i << IMM_W;
         default:   y_o = '0;
      endcase
   end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
   import int_exec_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int IMM_W        = 16,
   parameter int REGS         = 32,
   parameter bit SHARED_ADDER = 1'b1,
   parameter bit RESET_BANK   = 1'b1,
   localparam int AW          = $clog2(REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid_i,
   input  logic [31:0]       instr_i,
   output logic [DATA_W-1:0] result_o,
   output logic              wb_en_o,
   output logic [AW-1:0]     wb_addr_o,
   output logic              illegal_o
);

   // elaboration-time parameter checks
   if (IMM_W != 16) begin : g_bad_imm
      $error("int_exec_unit: IMM_W must match the 16-bit constant field");
   end
   if (DATA_W != 2 * IMM_W) begin : g_bad_data
      $error("int_exec_unit: DATA_W must be twice IMM_W");
   end
   if (REGS != (1 << RIDX_W)) begin : g_bad_regs
      $error("int_exec_unit: REGS must match the register index field");
   end

   logic [OPC_W-1:0]  f_opc;
   logic [RIDX_W-1:0] f_rs;
   logic [RIDX_W-1:0] f_rt;
   logic [RIDX_W-1:0] f_rd;
   logic [SH_W-1:0]   f_sh;
   logic [FN_W-1:0]   f_fn;
   logic [IMM_W-1:0]  f_imm;

   assign f_opc = instr_i[OPC_LSB +: OPC_W];
   assign f_rs  = instr_i[RS_LSB  +: RIDX_W];
   assign f_rt  = instr_i[RT_LSB  +: RIDX_W];
   assign f_rd  = instr_i[RD_LSB  +: RIDX_W];
   assign f_sh  = instr_i[SH_LSB  +: SH_W];
   assign f_fn  = instr_i[0 +: FN_W];
   assign f_imm = instr_i[0 +: IMM_W];

   dec_t dec;

   int_exec_decode u_dec (
      .opc_i (f_opc),
      .fn_i  (f_fn),
      .sh_i  (f_sh),
      .rt_i  (f_rt),
      .rd_i  (f_rd),
      .dec_o (dec)
   );

   logic [DATA_W-1:0] opa;
   logic [DATA_W-1:0] reg_b;
   logic [DATA_W-1:0] opb;
   logic              commit;

   int_exec_regfile #(
      .DATA_W     (DATA_W),
      .REGS       (REGS),
      .RESET_BANK (RESET_BANK)
   ) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .ra_a_i (AW'(f_rs)),
      .ra_b_i (AW'(f_rt)),
      .rd_a_o (opa),
      .rd_b_o (reg_b),
      .we_i   (commit),
      .wa_i   (AW'(dec.dst)),
      .wd_i   (result_o)
   );

   always_comb begin
      unique case (dec.srcb)
         SRCB_SEXT: opb = {{(DATA_W-IMM_W){f_imm[IMM_W-1]}}, f_imm};
         SRCB_ZEXT: opb = {{(DATA_W-IMM_W){1'b0}}, f_imm};
         default:   opb = reg_b;
      endcase
   end

   int_exec_alu #(
      .DATA_W       (DATA_W),
      .IMM_W        (IMM_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_alu (
      .a_i  (opa),
      .b_i  (opb),
      .op_i (dec.op),
      .y_o  (result_o)
   );

   assign commit    = instr_valid_i && dec.legal && (dec.dst != '0);
   assign wb_en_o   = commit;
   assign wb_addr_o = AW'(dec.dst);
   assign illegal_o = instr_valid_i && !dec.legal;

endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   parameter int AW     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid_i,
   input logic [31:0]       instr_i,
   input logic [DATA_W-1:0] result_o,
   input logic              wb_en_o,
   input logic [AW-1:0]     wb_addr_o,
   input logic              illegal_o
);

   logic [5:0] c_opc;
   logic [5:0] c_fn;
   logic [4:0] c_rs;
   logic [4:0] c_rt;
   assign c_opc = instr_i[31:26];
   assign c_fn  = instr_i[5:0];
   assign c_rs  = instr_i[25:21];
   assign c_rt  = instr_i[20:16];

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid_i |-> (!wb_en_o && !illegal_o));

   a_r9_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> !wb_en_o);

   a_r9_shamt_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid_i && c_opc == 6'd0 && instr_i[10:6] != 5'd0) |-> illegal_o);

   a_r8_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |-> (wb_addr_o != '0));

   a_r8_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid_i && c_opc == 6'd0 && c_fn == 6'd39 && c_rs == 5'd0 && c_rt == 5'd0
       && instr_i[10:6] == 5'd0) |-> (result_o == '1));

   a_r7_regreg_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en_o && c_opc == 6'd0) |-> (wb_addr_o == AW'(instr_i[15:11])));

   a_r7_const_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en_o && c_opc != 6'd0) |-> (wb_addr_o == AW'(c_rt)));

   a_r6_upper_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid_i && c_opc == 6'd15) |->
      (result_o[IMM_W-1:0] == '0 && result_o[DATA_W-1:IMM_W] == instr_i[IMM_W-1:0]));

   a_r5_andc_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid_i && c_opc == 6'd12) |-> (result_o[DATA_W-1:IMM_W] == '0));

   a_r11_next_sees_write: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wb_en_o) && instr_valid_i && c_opc == 6'd0 && c_fn == 6'd37
       && instr_i[10:6] == 5'd0 && c_rt == 5'd0 && AW'(c_rs) == $past(wb_addr_o))
      |-> (result_o == $past(result_o)));

endmodule

bind int_exec_unit int_exec_unit_chk #(
   .DATA_W (DATA_W),
   .IMM_W  (IMM_W),
   .AW     (AW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .instr_valid_i (instr_valid_i),
   .instr_i       (instr_i),
   .result_o      (result_o),
   .wb_en_o       (wb_en_o),
   .wb_addr_o     (wb_addr_o),
   .illegal_o     (illegal_o)
);

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid_i = 1'b0;
   logic [31:0] instr_i = '0;
   logic [31:0] result_o;
   logic        wb_en_o;
   logic [4:0]  wb_addr_o;
   logic        illegal_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [31:0] mregs [32];

   always #4 clk = ~clk;

   int_exec_unit u_int_exec_unit (
      .clk           (clk),
      .rst_n         (rst_n),
      .instr_valid_i (instr_valid_i),
      .instr_i       (instr_i),
      .result_o      (result_o),
      .wb_en_o       (wb_en_o),
      .wb_addr_o     (wb_addr_o),
      .illegal_o     (illegal_o)
   );

   function automatic logic [31:0] rr(input logic [5:0] fn, input logic [4:0] rd,
                                      input logic [4:0] rs, input logic [4:0] rt);
      return {6'd0, rs, rt, rd, 5'd0, fn};
   endfunction

   function automatic logic [31:0] ci(input logic [5:0] op, input logic [4:0] rt,
                                      input logic [4:0] rs, input logic [15:0] k);
      return {op, rs, rt, k};
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // one issue cycle: drive after the falling edge, compare 2 ns later, update model after rise
   task automatic step(input logic v, input logic [31:0] ins, input string tag);
      logic [5:0]  op;
      logic [5:0]  fn;
      logic [4:0]  rs;
      logic [4:0]  rt;
      logic [4:0]  dst;
      logic [15:0] k;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] res;
      logic        ok;
      logic        e_we;
      @(negedge clk);
      instr_valid_i = v;
      instr_i       = ins;
      #2;
      op = ins[31:26]; fn = ins[5:0]; rs = ins[25:21]; rt = ins[20:16]; k = ins[15:0];
      a = mregs[rs]; b = mregs[rt];
      ok = 1'b1; res = '0; dst = rt;
      case (op)
         6'd0: begin
            dst = ins[15:11];
            if (ins[10:6] != 5'd0) ok = 1'b0;
            case (fn)
               6'd32: res = a + b;
               6'd34: res = a - b;
               6'd36: res = a & b;
               6'd37: res = a | b;
               6'd38: res = a ^ b;
               6'd39: res = ~(a | b);
               default: ok = 1'b0;
            endcase
         end
         6'd8:  res = a + {{16{k[15]}}, k};
         6'd12: res = a & {16'h0, k};
         6'd13: res = a | {16'h0, k};
         6'd14: res = a ^ {16'h0, k};
         6'd15: res = {k, 16'h0};
         default: ok = 1'b0;
      endcase
      e_we = v && ok && (dst != 5'd0);
      check(tag, "wb_en", {31'd0, wb_en_o}, {31'd0, e_we});
      check(tag, "illegal", {31'd0, illegal_o}, {31'd0, v && !ok});
      if (v && ok) begin
         check(tag, "result", result_o, res);
         check(tag, "wb_addr", {27'd0, wb_addr_o}, {27'd0, dst});
      end
      @(posedge clk);
      if (e_we) mregs[dst] = res;
   endtask

   // read register r back through an OR with register 0 into rd
   task automatic peek(input logic [4:0] r, input string tag);
      step(1'b1, rr(6'd37, 5'd31, r, 5'd0), tag);
   endtask

   initial begin
      #(8 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired got running expected done");
      summary();
   end

   initial begin
      for (int i = 0; i < 32; i++) mregs[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R10", "wb_en in reset", {31'd0, wb_en_o}, 32'd0);
      rst_n = 1'b1;

      // R1: every register reads zero after reset
      for (int i = 0; i < 32; i++) peek(5'(i), "R1");
      // return r31 (peek target) to a known model state: it was written with 0 already

      // R4: sign-extended constant add
      step(1'b1, ci(6'd8, 5'd1, 5'd0, 16'hffff), "R4");
      step(1'b1, ci(6'd8, 5'd2, 5'd0, 16'h7fff), "R4");
      step(1'b1, ci(6'd8, 5'd3, 5'd2, 16'h8000), "R4");
      // R2: add, subtract, wrap
      step(1'b1, rr(6'd32, 5'd4, 5'd1, 5'd2), "R2");
      step(1'b1, ci(6'd15, 5'd5, 5'd0, 16'h8000), "R6");
      step(1'b1, rr(6'd32, 5'd6, 5'd5, 5'd5), "R2");
      step(1'b1, rr(6'd34, 5'd7, 5'd0, 5'd2), "R2");
      step(1'b1, rr(6'd34, 5'd8, 5'd0, 5'd1), "R2");
      // R3: logical register forms
      step(1'b1, ci(6'd15, 5'd9, 5'd0, 16'h2110), "R6");
      step(1'b1, ci(6'd13, 5'd9, 5'd9, 16'h003d), "R5");
      step(1'b1, rr(6'd36, 5'd10, 5'd9, 5'd2), "R3");
      step(1'b1, rr(6'd37, 5'd11, 5'd9, 5'd2), "R3");
      step(1'b1, rr(6'd38, 5'd12, 5'd9, 5'd1), "R3");
      step(1'b1, rr(6'd39, 5'd13, 5'd0, 5'd0), "R3");
      step(1'b1, rr(6'd39, 5'd14, 5'd9, 5'd2), "R3");
      // R5: zero-extended constants
      step(1'b1, ci(6'd12, 5'd15, 5'd1, 16'hffff), "R5");
      step(1'b1, ci(6'd14, 5'd16, 5'd1, 16'h00ff), "R5");
      step(1'b1, ci(6'd13, 5'd17, 5'd0, 16'h8001), "R5");
      // R6: load-upper ignores rs
      step(1'b1, ci(6'd15, 5'd18, 5'd1, 16'h1234), "R6");
      peek(5'd18, "R6");
      // R7: destination field choice, rt differs from rd
      step(1'b1, rr(6'd32, 5'd19, 5'd2, 5'd20), "R7");
      step(1'b1, ci(6'd8, 5'd20, 5'd19, 16'h0005), "R7");
      peek(5'd20, "R7");
      // R8: writes to register 0 are dropped
      step(1'b1, ci(6'd8, 5'd0, 5'd1, 16'h0005), "R8");
      step(1'b1, rr(6'd32, 5'd0, 5'd1, 5'd1), "R8");
      peek(5'd0, "R8");
      // R9: illegal opcode, function, nonzero shift field
      step(1'b1, ci(6'd35, 5'd2, 5'd1, 16'h0004), "R9");
      step(1'b1, rr(6'd33, 5'd2, 5'd1, 5'd1), "R9");
      step(1'b1, {6'd0, 5'd1, 5'd1, 5'd2, 5'd3, 6'd32}, "R9");
      step(1'b1, {6'd2, 26'h0000123}, "R9");
      peek(5'd2, "R9");
      // R10: valid low does nothing
      step(1'b0, ci(6'd8, 5'd11, 5'd1, 16'h0001), "R10");
      step(1'b0, {6'd63, 26'h3ffffff}, "R10");
      peek(5'd11, "R10");
      // R11: back-to-back dependency
      step(1'b1, ci(6'd8, 5'd21, 5'd0, 16'h0001), "R11");
      for (int i = 0; i < 8; i++) step(1'b1, rr(6'd32, 5'd21, 5'd21, 5'd21), "R11");
      peek(5'd21, "R11");

      // mixed stream
      for (int i = 0; i < 400; i++) begin
         logic [31:0] w;
         logic [5:0]  fsel [6];
         logic [5:0]  osel [5];
         int          pick;
         string       tg;
         fsel = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd38, 6'd39};
         osel = '{6'd8, 6'd12, 6'd13, 6'd14, 6'd15};
         w    = $urandom;
         pick = $urandom_range(0, 9);
         if (pick < 4) begin
            w = rr(fsel[$urandom_range(0, 5)], w[15:11], w[25:21], w[20:16]);
            tg = (w[5:0] == 6'd32 || w[5:0] == 6'd34) ? "R2" : "R3";
         end else if (pick < 8) begin
            w[31:26] = osel[$urandom_range(0, 4)];
            tg = (w[31:26] == 6'd8) ? "R4" : (w[31:26] == 6'd15) ? "R6" : "R5";
         end else begin
            tg = "R9";
         end
         step(pick != 9 || w[0], w, tg);
      end
      for (int i = 0; i < 32; i++) peek(5'(i), "R11");

      summary();
   end

endmodule